// File: doc/BRIEF.md
# DRAM Self-Refresh Entry and Exit Sequencer

This block puts an asynchronous DRAM into self-refresh for low-power data retention, and brings it back out, when a power manager asks. A sleep request first has the refresh scheduler run a complete burst of column-before-row refreshes over every row. As soon as that burst finishes, the sequencer takes the memory bus and drops the column strobe. It then drops the row strobe, keeping write-enable high. The row strobe stays low well past the 100 us point at which the memory reliably starts refreshing itself. Low times between 10 us and 100 us give an undefined result, so the block never releases early.

A wake request raises the column strobe a short, bounded time before the row strobe. The block then holds every strobe high for the extended post-exit precharge and hands the bus back. It then has the scheduler run a second full burst at once. The memory therefore gets a complete column-before-row pass on both sides of self-refresh, even if normal operation used row-only refresh. A wake that arrives while entry is still in progress is remembered and serviced once activation is complete.

All times are given in nanoseconds and turned into clock counts from the clock period.

Top module: `srf_seq`

## Requirements
- R1: While reset is asserted and after it is released, `ras_n_o`, `cas_n_o` and `we_n_o` are 1, and `bus_own_o`, `burst_req_o`, `busy_o` and `asleep_o` are 0.
- R2: A `sleep_req_i` sampled while idle raises `burst_req_o` and `busy_o` from the next cycle. The bus is not taken, and `burst_req_o` stays high until `burst_done_i` is sampled.
- R3: In the cycle after `burst_done_i` ends the entry burst, `bus_own_o` rises and `cas_n_o` goes low. `ras_n_o` follows after a setup of ceil(setup time / period) cycles (at least one). `we_n_o` stays 1 the whole time the block owns the bus.
- R4: `asleep_o` rises only after `ras_n_o` has been low for HOLD = floor(activation time / period) + 1 cycles. It stays high, with both strobes low and `busy_o` at 0, until a wake is serviced.
- R5: A wake while asleep drops `asleep_o`, raises `busy_o` and `cas_n_o`, and keeps `ras_n_o` low for LEAD = max(1, floor(lead time / period)) more cycles before `ras_n_o` rises.
- R6: A `wake_req_i` sampled during the entry burst, the column setup or the activation hold is held. When activation completes, `asleep_o` is high for exactly one cycle before exit begins.
- R7: After `ras_n_o` rises, all strobes stay high with the bus owned for ceil(precharge time / period) cycles. `bus_own_o` then drops and `burst_req_o` rises in the same cycle, well inside the post-exit refresh window.
- R8: `burst_done_i` sampled during the exit burst returns the block to the idle state of R1 in the next cycle.
- R9: `sleep_req_i` is ignored unless the block is idle. `wake_req_i` is ignored while idle or during exit. `burst_done_i` is ignored unless `burst_req_o` is high.
- R10: `bus_own_o` and `burst_req_o` are never high together, and the strobes leave their idle levels only while `bus_own_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_req_i | input | 1 | Power manager asks for self-refresh |
| wake_req_i | input | 1 | Power manager asks to leave self-refresh |
| burst_done_i | input | 1 | Refresh scheduler finished a full burst |
| burst_req_o | output | 1 | Asks the refresh scheduler for a full burst |
| bus_own_o | output | 1 | Sequencer drives the DRAM strobes |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe (both byte lanes), active low |
| we_n_o | output | 1 | Write enable, active low |
| busy_o | output | 1 | Entry or exit in progress |
| asleep_o | output | 1 | Memory is in self-refresh |

## Verification
The assertions take it that the refresh scheduler answers every burst request with a `burst_done_i` pulse reasonably soon. They also take it that the parameters keep the column-strobe lead under 50 ns and the precharge well below the post-exit refresh window. The stimulus stands in for the scheduler: it pulses `burst_done_i` a few cycles after each request, and it also sends stray `burst_done_i`, `sleep_req_i` and `wake_req_i` pulses at times when they must have no effect. Wakes are sent as single pulses and as held levels, and in every entry phase, so the held-wake path is covered as well as the direct one.

// File: rtl/srf_pkg.sv
package srf_pkg;

  typedef enum logic [2:0] {
    SRF_IDLE        = 3'd0,
    SRF_PRE_REF     = 3'd1,
    SRF_CAS_LEAD_IN = 3'd2,
    SRF_ACTIVATE    = 3'd3,
    SRF_RETAIN      = 3'd4,
    SRF_CAS_RELEASE = 3'd5,
    SRF_RECOVER     = 3'd6,
    SRF_POST_REF    = 3'd7
  } srf_state_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic own;
    logic burst_req;
    logic busy;
    logic asleep;
  } srf_pins_t;

  localparam srf_pins_t SRF_PINS_RST = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1,
                                         own: 1'b0, burst_req: 1'b0,
                                         busy: 1'b0, asleep: 1'b0};

  function automatic int ns_ceil_cyc(input int ns, input int period_ps);
    int c;
    c = (ns * 1000 + period_ps - 1) / period_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int ns_floor_cyc(input int ns, input int period_ps);
    int c;
    c = (ns * 1000) / period_ps;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/srf_phase_timer.sv
module srf_phase_timer
  import srf_pkg::*;
#(
  parameter int TW        = 16,
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 20001,
  parameter int LEAD_CYC  = 1,
  parameter int PRECH_CYC = 22
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  srf_state_e state_q_i,
  input  srf_state_e state_d_i,
  output logic       expired_o
);

  logic [TW-1:0] cnt_q, cnt_d, dur;
  logic          cnt_en, entering;

  always_comb begin
    unique case (state_d_i)
      SRF_CAS_LEAD_IN: dur = TW'(SETUP_CYC - 1);
      SRF_ACTIVATE:    dur = TW'(HOLD_CYC - 1);
      SRF_CAS_RELEASE: dur = TW'(LEAD_CYC - 1);
      SRF_RECOVER:     dur = TW'(PRECH_CYC - 1);
      default:         dur = '0;
    endcase
  end

  assign entering = (state_d_i != state_q_i);

  always_comb begin
    cnt_en = entering || (cnt_q != '0);
    if (entering) cnt_d = dur;
    else          cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

  // R4: an expired count never wraps while the phase is unchanged
  a_r4_timer_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && (state_d_i == state_q_i)) |=> expired_o);

endmodule

// File: rtl/srf_wake_hold.sv
module srf_wake_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wake_i,
  input  logic capture_i,
  input  logic clear_i,
  output logic pend_o
);

  logic pend_q, pend_d, pend_en;

  always_comb begin
    pend_en = clear_i || (wake_i && capture_i);
    pend_d  = !clear_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R6: a held wake is kept until the retain phase consumes it
  a_r6_pend_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !clear_i) |=> pend_o);

endmodule

// File: rtl/srf_fsm.sv
module srf_fsm
  import srf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_i,
  input  logic       wake_i,
  input  logic       burst_done_i,
  input  logic       expired_i,
  input  logic       pend_i,
  output srf_state_e state_q_o,
  output srf_state_e state_d_o
);

  srf_state_e state_q, state_d;
  logic       st_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SRF_IDLE:        if (sleep_i)           state_d = SRF_PRE_REF;
      SRF_PRE_REF:     if (burst_done_i)      state_d = SRF_CAS_LEAD_IN;
      SRF_CAS_LEAD_IN: if (expired_i)         state_d = SRF_ACTIVATE;
      SRF_ACTIVATE:    if (expired_i)         state_d = SRF_RETAIN;
      SRF_RETAIN:      if (wake_i || pend_i)  state_d = SRF_CAS_RELEASE;
      SRF_CAS_RELEASE: if (expired_i)         state_d = SRF_RECOVER;
      SRF_RECOVER:     if (expired_i)         state_d = SRF_POST_REF;
      SRF_POST_REF:    if (burst_done_i)      state_d = SRF_IDLE;
      default:                                state_d = SRF_IDLE;
    endcase
  end

  assign st_en = (state_d != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= SRF_IDLE;
    else if (st_en)  state_q <= state_d;
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;

  // R9: wake is not a way out of idle
  a_r9_idle_needs_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SRF_IDLE && !sleep_i) |=> state_q == SRF_IDLE);

endmodule

// File: rtl/srf_pin_drive.sv
module srf_pin_drive
  import srf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  srf_state_e state_d_i,
  output srf_pins_t  pins_o
);

  srf_pins_t pins_q, pins_d;
  logic      pins_en;

  always_comb begin
    pins_d = SRF_PINS_RST;
    unique case (state_d_i)
      SRF_PRE_REF, SRF_POST_REF: begin
        pins_d.burst_req = 1'b1;
        pins_d.busy      = 1'b1;
      end
      SRF_CAS_LEAD_IN: begin
        pins_d.own   = 1'b1;
        pins_d.cas_n = 1'b0;
        pins_d.busy  = 1'b1;
      end
      SRF_ACTIVATE: begin
        pins_d.own   = 1'b1;
        pins_d.cas_n = 1'b0;
        pins_d.ras_n = 1'b0;
        pins_d.busy  = 1'b1;
      end
      SRF_RETAIN: begin
        pins_d.own    = 1'b1;
        pins_d.cas_n  = 1'b0;
        pins_d.ras_n  = 1'b0;
        pins_d.asleep = 1'b1;
      end
      SRF_CAS_RELEASE: begin
        pins_d.own   = 1'b1;
        pins_d.ras_n = 1'b0;
        pins_d.busy  = 1'b1;
      end
      SRF_RECOVER: begin
        pins_d.own  = 1'b1;
        pins_d.busy = 1'b1;
      end
      default: pins_d = SRF_PINS_RST;
    endcase
  end

  assign pins_en = (pins_d != pins_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pins_q <= SRF_PINS_RST;
    else if (pins_en) pins_q <= pins_d;
  end

  assign pins_o = pins_q;

  // R3: write enable stays inactive on the bus
  a_r3_we_inactive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pins_q.own |-> pins_q.we_n);

  // R10: strobes idle whenever the bus is not ours
  a_r10_strobes_idle_off_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pins_q.own |-> (pins_q.ras_n && pins_q.cas_n && pins_q.we_n));

endmodule

// File: rtl/srf_seq.sv
module srf_seq
  import srf_pkg::*;
#(
  parameter int CLK_PERIOD_PS     = 5000,
  parameter int CBR_SETUP_NS      = 10,
  parameter int ACT_HOLD_NS       = 100000,
  parameter int EXIT_PRECH_NS     = 110,
  parameter int CAS_LEAD_NS       = 5,
  parameter int REFRESH_WINDOW_NS = 15600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_req_i,
  input  logic wake_req_i,
  input  logic burst_done_i,
  output logic burst_req_o,
  output logic bus_own_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o,
  output logic busy_o,
  output logic asleep_o
);

  localparam int SETUP_CYC = ns_ceil_cyc(CBR_SETUP_NS, CLK_PERIOD_PS);
  localparam int HOLD_CYC  = (ACT_HOLD_NS * 1000) / CLK_PERIOD_PS + 1;
  localparam int PRECH_CYC = ns_ceil_cyc(EXIT_PRECH_NS, CLK_PERIOD_PS);
  localparam int LEAD_CYC  = ns_floor_cyc(CAS_LEAD_NS, CLK_PERIOD_PS);
  localparam int WIN_CYC   = ns_floor_cyc(REFRESH_WINDOW_NS, CLK_PERIOD_PS);
  localparam int TW        = $clog2(HOLD_CYC + SETUP_CYC + LEAD_CYC + PRECH_CYC + 1);
  localparam int GW        = $clog2(WIN_CYC + PRECH_CYC + 2);

  srf_state_e state_q, state_d;
  srf_pins_t  pins;
  logic       expired, pend, capture, clear;

  assign capture = (state_q == SRF_PRE_REF) || (state_q == SRF_CAS_LEAD_IN) ||
                   (state_q == SRF_ACTIVATE);
  assign clear   = (state_q == SRF_RETAIN) && (state_d != SRF_RETAIN);

  srf_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sleep_i     (sleep_req_i),
    .wake_i      (wake_req_i),
    .burst_done_i(burst_done_i),
    .expired_i   (expired),
    .pend_i      (pend),
    .state_q_o   (state_q),
    .state_d_o   (state_d)
  );

  srf_phase_timer #(
    .TW       (TW),
    .SETUP_CYC(SETUP_CYC),
    .HOLD_CYC (HOLD_CYC),
    .LEAD_CYC (LEAD_CYC),
    .PRECH_CYC(PRECH_CYC)
  ) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .state_q_i(state_q),
    .state_d_i(state_d),
    .expired_o(expired)
  );

  srf_wake_hold i_wake_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wake_i   (wake_req_i),
    .capture_i(capture),
    .clear_i  (clear),
    .pend_o   (pend)
  );

  srf_pin_drive i_pins (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .state_d_i(state_d),
    .pins_o   (pins)
  );

  assign ras_n_o     = pins.ras_n;
  assign cas_n_o     = pins.cas_n;
  assign we_n_o      = pins.we_n;
  assign bus_own_o   = pins.own;
  assign burst_req_o = pins.burst_req;
  assign busy_o      = pins.busy;
  assign asleep_o    = pins.asleep;

  // Checker counters: row-strobe low time and post-exit high time
  logic [TW-1:0] low_q;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       low_q <= '0;
    else if (ras_n_o)                  low_q <= '0;
    else if (low_q != TW'(HOLD_CYC))   low_q <= low_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  gap_q <= '0;
    else if (!bus_own_o || !ras_n_o)              gap_q <= '0;
    else if (gap_q != {GW{1'b1}})                 gap_q <= gap_q + 1'b1;
  end

  // R2: burst request is held until the scheduler answers
  a_r2_burst_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_req_o && !burst_done_i) |=> burst_req_o);

  // R3: column strobe is low before and when the row strobe falls
  a_r3_cas_before_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (!cas_n_o && !$past(cas_n_o)));

  // R4: self-refresh reported only after the activation hold
  a_r4_hold_met: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(asleep_o) |-> (low_q >= TW'(HOLD_CYC)));

  a_r4_asleep_strobes_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asleep_o |-> (!ras_n_o && !cas_n_o && !busy_o));

  // R5: column strobe already high when the row strobe rises
  a_r5_cas_leads_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> (cas_n_o && $past(cas_n_o)));

  // R6: a held wake ends self-refresh after one reported cycle
  a_r6_pending_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (asleep_o && pend) |=> !asleep_o);

  // R7: post-exit precharge length and burst inside its window
  a_r7_prech_then_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(bus_own_o) && burst_req_o) |->
      (gap_q >= GW'(PRECH_CYC) && gap_q <= GW'(WIN_CYC)));

  // R10: bus and burst request never together
  a_r10_own_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_own_o && burst_req_o));

endmodule

// File: tb/test_srf_seq.sv
module test_srf_seq;

  localparam int PER_PS  = 5000;
  localparam int T_SETUP = 10;
  localparam int T_HOLD  = 300;
  localparam int T_PRECH = 110;
  localparam int T_LEAD  = 10;
  localparam int T_WIN   = 15600;

  // Expected cycle counts worked out from the requirements
  localparam int E_SETUP = 2;
  localparam int E_HOLD  = 61;
  localparam int E_PRECH = 22;
  localparam int E_LEAD  = 2;

  logic clk, rst_n, sleep_req, wake_req, burst_done;
  logic burst_req, bus_own, ras_n, cas_n, we_n, busy, asleep;

  int compared = 0;
  int mismatched = 0;

  srf_seq #(
    .CLK_PERIOD_PS    (PER_PS),
    .CBR_SETUP_NS     (T_SETUP),
    .ACT_HOLD_NS      (T_HOLD),
    .EXIT_PRECH_NS    (T_PRECH),
    .CAS_LEAD_NS      (T_LEAD),
    .REFRESH_WINDOW_NS(T_WIN)
  ) i_srf_seq (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sleep_req_i (sleep_req),
    .wake_req_i  (wake_req),
    .burst_done_i(burst_done),
    .burst_req_o (burst_req),
    .bus_own_o   (bus_own),
    .ras_n_o     (ras_n),
    .cas_n_o     (cas_n),
    .we_n_o      (we_n),
    .busy_o      (busy),
    .asleep_o    (asleep)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Behavioural reference: phase number, cycles left, held wake
  int  ph;
  int  left;
  bit  held;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; left = 0; held = 0;
    end else begin
      case (ph)
        0: if (sleep_req) ph = 1;
        1: begin
             if (wake_req) held = 1;
             if (burst_done) begin ph = 2; left = E_SETUP; end
           end
        2: begin
             if (wake_req) held = 1;
             left = left - 1;
             if (left == 0) begin ph = 3; left = E_HOLD; end
           end
        3: begin
             if (wake_req) held = 1;
             left = left - 1;
             if (left == 0) ph = 4;
           end
        4: if (wake_req || held) begin ph = 5; left = E_LEAD; held = 0; end
        5: begin
             left = left - 1;
             if (left == 0) begin ph = 6; left = E_PRECH; end
           end
        6: begin
             left = left - 1;
             if (left == 0) ph = 7;
           end
        default: if (burst_done) ph = 0;
      endcase
    end
  end

  // {ras_n, cas_n, we_n, own, burst_req, busy, asleep}
  function automatic logic [6:0] expect_pins(input int p);
    case (p)
      0: return 7'b1110000;
      1: return 7'b1110110;
      2: return 7'b1011010;
      3: return 7'b0011010;
      4: return 7'b0011001;
      5: return 7'b0111010;
      6: return 7'b1111010;
      default: return 7'b1110110;
    endcase
  endfunction

  function automatic string tag_of(input int p);
    case (p)
      0: return "R1 R8 R9";
      1: return "R2";
      2: return "R3 R10";
      3: return "R4";
      4: return "R4 R9";
      5: return "R5";
      6: return "R7 R10";
      default: return "R7 R8";
    endcase
  endfunction

  task automatic check_int(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: whole-pin compare each cycle plus interval measurements
  bit expect_one = 0;
  int low_run = 0, asleep_run = 0, lead_run = 0, prech_run = 0;
  bit prev_ras = 1, prev_asleep = 0, in_prech = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      logic [6:0] act;
      act = {ras_n, cas_n, we_n, bus_own, burst_req, busy, asleep};
      compared++;
      if (act !== expect_pins(ph)) begin
        mismatched++;
        $display("FAIL %s pins actual=%b expected=%b", tag_of(ph), act, expect_pins(ph));
      end
      if (!ras_n) low_run++;
      if (asleep) asleep_run++;
      if (!ras_n && cas_n) lead_run++;
      if (!prev_ras && ras_n) begin
        // R4: row strobe low longer than the activation hold
        compared++;
        if (low_run <= E_HOLD) begin
          mismatched++;
          $display("FAIL R4 ras low actual=%0d expected>%0d", low_run, E_HOLD);
        end
        check_int("R5 cas lead", lead_run, E_LEAD);
        low_run = 0; lead_run = 0; in_prech = 1; prech_run = 0;
      end
      if (in_prech) begin
        if (burst_req) begin
          check_int("R7 precharge", prech_run, E_PRECH);
          in_prech = 0;
        end else prech_run++;
      end
      if (prev_asleep && !asleep) begin
        if (expect_one) check_int("R6 asleep cycles", asleep_run, 1);
        asleep_run = 0;
      end
      prev_ras = ras_n;
      prev_asleep = asleep;
    end
  end

  task automatic serve_burst(input int lat);
    while (!burst_req) @(negedge clk);
    repeat (lat) @(negedge clk);
    burst_done = 1'b1;
    @(negedge clk);
    burst_done = 1'b0;
  endtask

  task automatic pulse_sleep();
    sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
  endtask

  task automatic pulse_wake();
    wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sleep_req = 1'b0; wake_req = 1'b0; burst_done = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs at rest during reset
    check_int("R1 reset pins", int'({ras_n, cas_n, we_n, bus_own, burst_req, busy, asleep}),
              int'(7'b1110000));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Normal cycle, stray sleep while asleep (R9)
    pulse_sleep();
    serve_burst(5);
    while (!asleep) @(negedge clk);
    repeat (20) @(negedge clk);
    pulse_sleep();
    repeat (5) @(negedge clk);
    pulse_wake();
    serve_burst(3);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);

    // R6: wake during activation hold
    expect_one = 1;
    pulse_sleep();
    serve_burst(2);
    while (ras_n) @(negedge clk);
    repeat (10) @(negedge clk);
    pulse_wake();
    serve_burst(4);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);

    // R6: wake during entry burst
    pulse_sleep();
    repeat (2) @(negedge clk);
    pulse_wake();
    serve_burst(6);
    serve_burst(2);
    while (busy) @(negedge clk);
    expect_one = 0;
    repeat (3) @(negedge clk);

    // R9: wake and stray burst_done while idle
    pulse_wake();
    burst_done = 1'b1; @(negedge clk); burst_done = 1'b0;
    repeat (5) @(negedge clk);

    // Wake held as a level; stray wake during exit (R9)
    pulse_sleep();
    serve_burst(1);
    while (!asleep) @(negedge clk);
    repeat (3) @(negedge clk);
    wake_req = 1'b1;
    repeat (4) @(negedge clk);
    wake_req = 1'b0;
    serve_burst(7);
    while (busy) @(negedge clk);
    repeat (5) @(negedge clk);

    finish_run();
  end

endmodule